// File: doc/BRIEF.md
# Video Expansion Port Input Front-End

This block sits at the input edge of a video scaler. It receives an 8-bit byte stream on its own clock, together with a data qualifier and two reference levels: a horizontal reference and a vertical reference. From these it produces three outputs. The first is a single-cycle start trigger for each direction of the acquisition window. The second is a field identifier. The third is a registered copy of the byte with a strobe that marks the bytes to be taken.

Timing can come from the reference pins. It can also come from timing codes embedded in the byte stream. An embedded code is the preamble FF, 00, 00 followed by a status byte. In the status byte, bit 6 is the field bit F, bit 5 is the vertical blanking bit V, and bit 4 is the horizontal bit H. H=0 marks start of active video and H=1 marks end of active video. When codes are used, the decoded H and V bits take the place of the reference pins.

The field identifier has three possible sources:
- the edge phase of the vertical reference combined with the horizontal reference level;
- the plain level of the vertical pin, used as a frame-sync signal;
- in code mode, the F bit.

All configuration inputs are sampled together with the data byte. A setting therefore applies to the sample that arrives in the same cycle.

Internally a byte first passes a capture stage. In pin mode, a pin change reaches the outputs after two clock edges. In code mode, a status byte reaches the triggers and the field identifier after three clock edges, because of the extra decoded-level register. The code parser is a state machine with four states:
- `PS_IDLE`: no preamble seen.
- `PS_ONES`: an FF byte was seen.
- `PS_ZERO1`: FF, 00 were seen.
- `PS_ZERO2`: FF, 00, 00 were seen, so the next qualified byte is the status byte.

Its transitions happen only on qualified bytes:
- An FF byte moves any state except `PS_ZERO2` to `PS_ONES`.
- A 00 byte moves `PS_ONES` to `PS_ZERO1`, and `PS_ZERO1` to `PS_ZERO2`.
- Any other byte moves `PS_IDLE`, `PS_ONES` or `PS_ZERO1` to `PS_IDLE`.
- Any byte in `PS_ZERO2` is taken as the status byte and returns the parser to `PS_IDLE`.

Top module: `vid_xport_rx`

## Requirements
- R1: With `cfg_h_fall`=0 a rising edge of the effective horizontal reference produces a one-cycle `acq_h_trig`; with `cfg_h_fall`=1 a falling edge does. In pin mode the pulse appears after the second rising clock edge following the pin change.
- R2: `cfg_v_mode` selects the vertical trigger: 0 is rising edge, 1 is falling edge, and 2 or 3 is both edges. `acq_v_trig` is a one-cycle pulse with the same latency as R1.
- R3: A byte is qualified when `xqual_i` equals `cfg_qual_high` (1 = qualifier active high). `px_stb` is 1 two clock edges after a qualified byte and 0 after an unqualified one, and `px_data` then carries that byte.
- R4: With `cfg_gated_clk`=1 every byte is qualified whatever `xqual_i` is.
- R5: With `cfg_use_codes`=1 the qualified byte sequence FF, 00, 00, S is taken as a timing code. Bit 4 of S drives the effective horizontal reference and bit 5 of S drives the effective vertical reference. Triggers from a code appear after the third rising clock edge following S.
- R6: Bit 7 and bits 3..0 of the status byte (the protection bits) are ignored.
- R7: Unqualified bytes neither advance nor break code recognition. A qualified byte outside the preamble pattern restarts the search, so no code is taken.
- R8: With `cfg_use_codes`=0 and `cfg_fid_level`=0, on every edge of the vertical reference `field_id` becomes the horizontal reference level XOR (1 for a falling edge, 0 for a rising edge). The horizontal level used is the one at the moment of the vertical edge, and `field_id` is updated in the same cycle as the triggers.
- R9: With `cfg_use_codes`=0 and `cfg_fid_level`=1, `field_id` follows the level of `xvref_i` with a latency of two clock edges.
- R10: With `cfg_use_codes`=1, `field_id` equals bit 6 of the last status byte, with the latency of R5.
- R11: After reset, `acq_h_trig`, `acq_v_trig`, `field_id` and `px_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock (also the gated clock in gated mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| xd_i | input | 8 | Input video byte |
| xqual_i | input | 1 | Data qualifier |
| xhref_i | input | 1 | Horizontal reference pin |
| xvref_i | input | 1 | Vertical reference / frame-sync pin |
| cfg_h_fall | input | 1 | Horizontal trigger edge: 0 rising, 1 falling |
| cfg_v_mode | input | 2 | Vertical trigger: 0 rising, 1 falling, 2/3 both |
| cfg_qual_high | input | 1 | Qualifier active level |
| cfg_gated_clk | input | 1 | Treat every byte as qualified |
| cfg_use_codes | input | 1 | Take timing from embedded codes instead of pins |
| cfg_fid_level | input | 1 | Field from vertical pin level instead of edge phase |
| acq_h_trig | output | 1 | Horizontal acquisition start pulse |
| acq_v_trig | output | 1 | Vertical acquisition start pulse |
| field_id | output | 1 | Field identifier |
| px_data | output | 8 | Registered byte |
| px_stb | output | 1 | Qualified data strobe |

## Verification
The bench walks the edge selections. It checks for the case where the unselected edge still fires, and for a both-edges mode that misses one direction. It also drives the edge-phase field rule with every combination of vertical edge and horizontal level, since a design that swapped the phase would report the opposite field. In code mode it sends status bytes with the protection bits set and bit 7 cleared, a preamble interrupted by an unqualified byte, and a preamble broken by a stray byte. A parser that checked protection, or that reset on unqualified bytes, would lose real codes, and a parser that did not restart its search would accept a false one. Qualifier polarity and gated mode are exercised with the qualifier held at its inactive level, where an inverted polarity or an ignored gated setting would drop or invent strobes.

// File: rtl/vx_pkg.sv
package vx_pkg;
    localparam int unsigned VX_DW = 8;
    localparam int unsigned VX_BIT_F = 6;
    localparam int unsigned VX_BIT_V = 5;
    localparam int unsigned VX_BIT_H = 4;

    typedef enum logic [1:0] {
        VM_RISE     = 2'd0,
        VM_FALL     = 2'd1,
        VM_BOTH     = 2'd2,
        VM_BOTH_ALT = 2'd3
    } vmode_e;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_ONES,
        PS_ZERO1,
        PS_ZERO2
    } pstate_e;
endpackage

// File: rtl/vx_edge_det.sv
module vx_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    always_comb begin
        rise_o = lvl_i & ~prev_q;
        fall_o = ~lvl_i & prev_q;
    end
endmodule

// File: rtl/vx_code_parse.sv
module vx_code_parse #(
    parameter int unsigned DW    = vx_pkg::VX_DW,
    parameter int unsigned BIT_F = vx_pkg::VX_BIT_F,
    parameter int unsigned BIT_V = vx_pkg::VX_BIT_V,
    parameter int unsigned BIT_H = vx_pkg::VX_BIT_H
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] byte_i,
    input  logic          vld_i,
    output logic          h_lvl_o,
    output logic          v_lvl_o,
    output logic          f_lvl_o
);
    import vx_pkg::*;

    localparam logic [DW-1:0] ONES  = {DW{1'b1}};
    localparam logic [DW-1:0] ZEROS = {DW{1'b0}};

    pstate_e state_q, state_d;
    logic    is_ones, is_zero;

    always_comb begin
        is_ones = (byte_i == ONES);
        is_zero = (byte_i == ZEROS);
    end

    always_comb begin
        state_d = state_q;
        if (vld_i) begin
            unique case (state_q)
                PS_IDLE:  state_d = is_ones ? PS_ONES : PS_IDLE;
                PS_ONES:  state_d = is_zero ? PS_ZERO1 : (is_ones ? PS_ONES : PS_IDLE);
                PS_ZERO1: state_d = is_zero ? PS_ZERO2 : (is_ones ? PS_ONES : PS_IDLE);
                PS_ZERO2: state_d = PS_IDLE;
                default:  state_d = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // status byte: only F, V and H are taken; the protection bits are dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_lvl_o <= 1'b0;
            v_lvl_o <= 1'b0;
            f_lvl_o <= 1'b0;
        end else if (vld_i && state_q == PS_ZERO2) begin
            h_lvl_o <= byte_i[BIT_H];
            v_lvl_o <= byte_i[BIT_V];
            f_lvl_o <= byte_i[BIT_F];
        end
    end
endmodule

// File: rtl/vx_field_gen.sv
module vx_field_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic use_codes_i,
    input  logic use_level_i,
    input  logic v_rise_i,
    input  logic v_fall_i,
    input  logic h_lvl_i,
    input  logic fs_lvl_i,
    input  logic code_f_i,
    output logic field_o
);
    typedef enum logic [1:0] {FS_CODE, FS_LEVEL, FS_PHASE} fsrc_e;
    fsrc_e src;

    always_comb begin
        if (use_codes_i)      src = FS_CODE;
        else if (use_level_i) src = FS_LEVEL;
        else                  src = FS_PHASE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) field_o <= 1'b0;
        else begin
            unique case (src)
                FS_CODE:  field_o <= code_f_i;
                FS_LEVEL: field_o <= fs_lvl_i;
                FS_PHASE: if (v_rise_i || v_fall_i) field_o <= h_lvl_i ^ v_fall_i;
                default:  field_o <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/vid_xport_rx.sv
module vid_xport_rx #(
    parameter int unsigned DW = vx_pkg::VX_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] xd_i,
    input  logic          xqual_i,
    input  logic          xhref_i,
    input  logic          xvref_i,
    input  logic          cfg_h_fall,
    input  logic [1:0]    cfg_v_mode,
    input  logic          cfg_qual_high,
    input  logic          cfg_gated_clk,
    input  logic          cfg_use_codes,
    input  logic          cfg_fid_level,
    output logic          acq_h_trig,
    output logic          acq_v_trig,
    output logic          field_id,
    output logic [DW-1:0] px_data,
    output logic          px_stb
);
    import vx_pkg::*;

    localparam int unsigned NREF = 2;   // 0 = horizontal, 1 = vertical

    logic [DW-1:0] d_q;
    logic          ok_q, href_q, vref_q, hfall_q, codes_q, fidlvl_q;
    vmode_e        vmode_q;
    logic          code_h, code_v, code_f;
    logic [NREF-1:0] eff, rise, fall;
    logic          h_hit, v_hit;

    // capture stage: sample and configuration travel together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q      <= '0;
            ok_q     <= 1'b0;
            href_q   <= 1'b0;
            vref_q   <= 1'b0;
            hfall_q  <= 1'b0;
            vmode_q  <= VM_RISE;
            codes_q  <= 1'b0;
            fidlvl_q <= 1'b0;
        end else begin
            d_q      <= xd_i;
            ok_q     <= cfg_gated_clk | (xqual_i == cfg_qual_high);
            href_q   <= xhref_i;
            vref_q   <= xvref_i;
            hfall_q  <= cfg_h_fall;
            vmode_q  <= vmode_e'(cfg_v_mode);
            codes_q  <= cfg_use_codes;
            fidlvl_q <= cfg_fid_level;
        end
    end

    vx_code_parse #(.DW(DW)) u_parse (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_i  (d_q),
        .vld_i   (ok_q),
        .h_lvl_o (code_h),
        .v_lvl_o (code_v),
        .f_lvl_o (code_f)
    );

    always_comb begin
        eff[0] = codes_q ? code_h : href_q;
        eff[1] = codes_q ? code_v : vref_q;
    end

    for (genvar g = 0; g < NREF; g++) begin : g_edge
        vx_edge_det u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (eff[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    always_comb begin
        h_hit = hfall_q ? fall[0] : rise[0];
        unique case (vmode_q)
            VM_RISE:     v_hit = rise[1];
            VM_FALL:     v_hit = fall[1];
            VM_BOTH,
            VM_BOTH_ALT: v_hit = rise[1] | fall[1];
            default:     v_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acq_h_trig <= 1'b0;
            acq_v_trig <= 1'b0;
            px_data    <= '0;
            px_stb     <= 1'b0;
        end else begin
            acq_h_trig <= h_hit;
            acq_v_trig <= v_hit;
            px_data    <= d_q;
            px_stb     <= ok_q;
        end
    end

    vx_field_gen u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .use_codes_i (codes_q),
        .use_level_i (fidlvl_q),
        .v_rise_i    (rise[1]),
        .v_fall_i    (fall[1]),
        .h_lvl_i     (eff[0]),
        .fs_lvl_i    (vref_q),
        .code_f_i    (code_f),
        .field_o     (field_id)
    );
endmodule

// File: rtl/vx_xport_chk.sv
module vx_xport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       xqual_i,
    input logic       xhref_i,
    input logic       xvref_i,
    input logic       cfg_h_fall,
    input logic       cfg_qual_high,
    input logic       cfg_gated_clk,
    input logic       cfg_use_codes,
    input logic       cfg_fid_level,
    input logic       acq_h_trig,
    input logic       acq_v_trig,
    input logic       field_id,
    input logic       px_stb
);
    // R1: pin-mode rising-edge trigger only follows a real rising edge
    a_r1_h_rise_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_h_trig && $past(rst_n, 3) && !$past(cfg_use_codes, 2) && !$past(cfg_use_codes, 3)
         && !$past(cfg_h_fall, 2))
        |-> ($past(xhref_i, 2) && !$past(xhref_i, 3)));

    // R2: pin-mode vertical trigger only follows a change of the vertical pin
    a_r2_v_edge_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_v_trig && $past(rst_n, 3) && !$past(cfg_use_codes, 2) && !$past(cfg_use_codes, 3))
        |-> ($past(xvref_i, 2) != $past(xvref_i, 3)));

    // R3: a strobe needs the qualifier at its programmed level unless gated
    a_r3_stb_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        px_stb |-> ($past(cfg_gated_clk, 2) || ($past(xqual_i, 2) == $past(cfg_qual_high, 2))));

    // R4: gated mode strobes every sample
    a_r4_gated_all: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(cfg_gated_clk, 2)) |-> px_stb);

    // R9: level-sourced field follows the vertical pin
    a_r9_fs_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && !$past(cfg_use_codes, 2) && $past(cfg_fid_level, 2))
        |-> (field_id == $past(xvref_i, 2)));

    // R1: horizontal trigger never lasts more than one cycle on a steady pin
    a_r1_h_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_h_trig && !cfg_use_codes && !$past(cfg_use_codes) && !$past(cfg_use_codes, 2)
         && $stable(xhref_i)) |=> !acq_h_trig);
endmodule

bind vid_xport_rx vx_xport_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xqual_i       (xqual_i),
    .xhref_i       (xhref_i),
    .xvref_i       (xvref_i),
    .cfg_h_fall    (cfg_h_fall),
    .cfg_qual_high (cfg_qual_high),
    .cfg_gated_clk (cfg_gated_clk),
    .cfg_use_codes (cfg_use_codes),
    .cfg_fid_level (cfg_fid_level),
    .acq_h_trig    (acq_h_trig),
    .acq_v_trig    (acq_v_trig),
    .field_id      (field_id),
    .px_stb        (px_stb)
);

// File: tb/sim_vid_xport_rx.sv
`timescale 1ns/1ps
module sim_vid_xport_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] xd_i = 8'h00;
    logic       xqual_i = 1'b0, xhref_i = 1'b0, xvref_i = 1'b0;
    logic       cfg_h_fall = 1'b0, cfg_qual_high = 1'b1, cfg_gated_clk = 1'b0;
    logic       cfg_use_codes = 1'b0, cfg_fid_level = 1'b0;
    logic [1:0] cfg_v_mode = 2'd0;
    logic       acq_h_trig, acq_v_trig, field_id, px_stb;
    logic [7:0] px_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    vid_xport_rx u0 (
        .clk(clk), .rst_n(rst_n), .xd_i(xd_i), .xqual_i(xqual_i),
        .xhref_i(xhref_i), .xvref_i(xvref_i), .cfg_h_fall(cfg_h_fall),
        .cfg_v_mode(cfg_v_mode), .cfg_qual_high(cfg_qual_high),
        .cfg_gated_clk(cfg_gated_clk), .cfg_use_codes(cfg_use_codes),
        .cfg_fid_level(cfg_fid_level), .acq_h_trig(acq_h_trig),
        .acq_v_trig(acq_v_trig), .field_id(field_id), .px_data(px_data),
        .px_stb(px_stb)
    );

    typedef struct packed {
        logic       hf;
        logic [1:0] vm;
        logic       pol;
        logic       h;
        logic       v;
        logic       q;
        logic [7:0] d;
        logic       eh;
        logic       ev;
        logic       es;
        logic       ef;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h22, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h66, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h88, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hAA, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 8'hBB, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'hCC, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 8'hDD, 1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'hEE, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [7:0] b, input logic q);
        xd_i = b;
        xqual_i = q;
        tick();
    endtask

    // sends preamble and status, optional unqualified byte after FF, then two fillers
    task automatic code_seq(input logic [7:0] st, input bit gap);
        put(8'hFF, 1'b1);
        if (gap) put(8'h33, 1'b0);
        put(8'h00, 1'b1);
        put(8'h00, 1'b1);
        put(st, 1'b1);
        put(8'h10, 1'b1);
        put(8'h10, 1'b1);
    endtask

    task automatic apply(input vec_t t);
        cfg_h_fall = t.hf;
        cfg_v_mode = t.vm;
        cfg_qual_high = t.pol;
        xhref_i = t.h;
        xvref_i = t.v;
        xqual_i = t.q;
        xd_i = t.d;
    endtask

    task automatic check_row(input vec_t t);
        chk("R1 h trig", {7'd0, acq_h_trig}, {7'd0, t.eh});
        chk("R2 v trig", {7'd0, acq_v_trig}, {7'd0, t.ev});
        chk("R3 strobe", {7'd0, px_stb}, {7'd0, t.es});
        chk("R8 field phase", {7'd0, field_id}, {7'd0, t.ef});
        if (t.es) chk("R3 data", px_data, t.d);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R11 reset state
        chk("R11 h", {7'd0, acq_h_trig}, 8'd0);
        chk("R11 v", {7'd0, acq_v_trig}, 8'd0);
        chk("R11 field", {7'd0, field_id}, 8'd0);
        chk("R11 stb", {7'd0, px_stb}, 8'd0);
        rst_n = 1'b1;
        tick();
        tick();

        // table walk, pin mode
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            tick();
            if (i > 0) check_row(TBL[i-1]);
        end
        apply('{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0});
        tick();
        check_row(TBL[NV-1]);
        xhref_i = 1'b0;
        repeat (3) tick();

        // R4 gated: qualifier inactive but all samples valid
        cfg_gated_clk = 1'b1;
        put(8'h3C, 1'b0);
        cfg_gated_clk = 1'b0;
        put(8'h00, 1'b0);
        chk("R4 gated stb", {7'd0, px_stb}, 8'd1);
        chk("R4 gated data", px_data, 8'h3C);
        tick();
        chk("R3 inactive qual", {7'd0, px_stb}, 8'd0);

        // R9 level field
        cfg_fid_level = 1'b1;
        xvref_i = 1'b1;
        tick();
        tick();
        chk("R9 fs high", {7'd0, field_id}, 8'd1);
        xvref_i = 1'b0;
        tick();
        tick();
        chk("R9 fs low", {7'd0, field_id}, 8'd0);
        cfg_fid_level = 1'b0;
        repeat (3) tick();

        // embedded codes
        cfg_use_codes = 1'b1;
        cfg_h_fall = 1'b0;
        cfg_v_mode = 2'd2;
        cfg_qual_high = 1'b1;
        repeat (3) put(8'h10, 1'b1);

        code_seq(8'h90, 1'b0);
        chk("R5 EAV h trig", {7'd0, acq_h_trig}, 8'd1);
        chk("R5 EAV no v", {7'd0, acq_v_trig}, 8'd0);
        chk("R10 field F0", {7'd0, field_id}, 8'd0);
        put(8'h10, 1'b1);
        chk("R1 single pulse", {7'd0, acq_h_trig}, 8'd0);

        code_seq(8'hE0, 1'b0);
        chk("R5 SAV no h (falling)", {7'd0, acq_h_trig}, 8'd0);
        chk("R5 V rise", {7'd0, acq_v_trig}, 8'd1);
        chk("R10 field F1", {7'd0, field_id}, 8'd1);

        code_seq(8'h5F, 1'b0);
        chk("R6 prot ignored h", {7'd0, acq_h_trig}, 8'd1);
        chk("R6 prot ignored v", {7'd0, acq_v_trig}, 8'd1);
        chk("R6 prot field", {7'd0, field_id}, 8'd1);

        code_seq(8'hB0, 1'b1);
        chk("R7 gap v rise", {7'd0, acq_v_trig}, 8'd1);
        chk("R7 gap field", {7'd0, field_id}, 8'd0);

        put(8'hFF, 1'b1);
        put(8'h00, 1'b1);
        put(8'h05, 1'b1);
        put(8'h00, 1'b1);
        put(8'hD0, 1'b1);
        put(8'h10, 1'b1);
        put(8'h10, 1'b1);
        chk("R7 broken no v", {7'd0, acq_v_trig}, 8'd0);
        chk("R7 broken field", {7'd0, field_id}, 8'd0);
        put(8'h10, 1'b1);
        chk("R7 broken still no v", {7'd0, acq_v_trig}, 8'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule